// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Registers

This block lets two bus domains that share one clock raise interrupts toward each other. It holds two doorbell registers of `WIDTH` bits. The inbound bell interrupts the local processor, and the outbound bell interrupts the external host. Each bell has one side that may only set bits and one side that may only clear them. In both cases a bit changes only where the written word holds a one. Because neither side can overwrite the other's pending events, software on either side can post events without a read-modify-write race.

A small enable register holds one enable bit for each bell. Each interrupt output is a level signal. It is high while its enable bit is one and at least one bit of its bell is set. Each side has its own write port, made of a strobe, a two-bit slot address and data, and its own combinational read port. Reads never change state.

Top module: `bell_exchange`

## Requirements
- R1: After reset both bells and the enable register read zero from both sides, and both interrupt outputs are low.
- R2: A host write to slot 0 (inbound bell) sets every bit where the data holds a one. A local write to slot 0 clears every bit where the data holds a one. The update is visible on the read ports and the interrupt outputs in the cycle after the write edge.
- R3: A local write to slot 1 (outbound bell) sets every bit where the data holds a one. A host write to slot 1 clears every bit where the data holds a one.
- R4: Bits where the written data holds a zero keep their value, whichever side writes.
- R5: When a set and a clear reach the same bit of a bell in the same cycle, the bit ends up set. Other cleared bits still clear.
- R6: Slot 2 is the enable register. Bit 0 enables the inbound interrupt and bit 1 enables the outbound interrupt. Only the local side can write it, and a host write to slot 2 leaves it unchanged. Both sides read it zero-extended.
- R7: `irq_loc` is high exactly when enable bit 0 is one and the inbound bell is nonzero. `irq_host` is high exactly when enable bit 1 is one and the outbound bell is nonzero. Both outputs are levels.
- R8: Slot 3 reads zero, and writes to it change nothing. Reads from either side at any slot have no effect on state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host write slot |
| host_wdata | input | WIDTH | Host write data |
| host_raddr | input | 2 | Host read slot |
| host_rdata | output | WIDTH | Host read data |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | 2 | Local write slot |
| loc_wdata | input | WIDTH | Local write data |
| loc_raddr | input | 2 | Local read slot |
| loc_rdata | output | WIDTH | Local read data |
| irq_loc | output | 1 | Level interrupt toward the local processor |
| irq_host | output | 1 | Level interrupt toward the host |

## Verification
The assertions assume that write strobes, slots and data are known and steady at each rising edge, and that the reset is held for at least one edge. The assertions also rely on `WIDTH` being at least 2, so that the enable bits fit in the read data. The bench changes inputs only on falling edges and holds reset across several edges. It runs a narrow 4-bit configuration so that it can sweep every combination of starting bell value, set mask and clear mask. The enable value cycles through its four settings during the sweep.

// File: rtl/bell_pkg.sv
package bell_pkg;

    typedef enum logic [1:0] {
        SLOT_INB  = 2'd0,
        SLOT_OUTB = 2'd1,
        SLOT_ENA  = 2'd2,
        SLOT_RSVD = 2'd3
    } bell_slot_e;

    localparam int ENA_BITS = 2;
    localparam int ENA_INB  = 0;
    localparam int ENA_OUTB = 1;
    localparam int NUM_BELLS = 2;

endpackage

// File: rtl/bell_decode.sv
module bell_decode
    import bell_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                                   host_we,
    input  logic [1:0]                             host_addr,
    input  logic [WIDTH-1:0]                       host_wdata,
    input  logic                                   loc_we,
    input  logic [1:0]                             loc_addr,
    input  logic [WIDTH-1:0]                       loc_wdata,
    output logic [NUM_BELLS-1:0][WIDTH-1:0]        set_mask,
    output logic [NUM_BELLS-1:0][WIDTH-1:0]        clr_mask,
    output logic                                   ena_we,
    output logic [ENA_BITS-1:0]                    ena_wdata
);

    logic host_inb, host_outb, loc_inb, loc_outb;

    always_comb begin
        host_inb  = host_we && (bell_slot_e'(host_addr) == SLOT_INB);
        host_outb = host_we && (bell_slot_e'(host_addr) == SLOT_OUTB);
        loc_inb   = loc_we  && (bell_slot_e'(loc_addr)  == SLOT_INB);
        loc_outb  = loc_we  && (bell_slot_e'(loc_addr)  == SLOT_OUTB);

        // inbound bell: host sets, local clears
        set_mask[0] = host_inb ? host_wdata : '0;
        clr_mask[0] = loc_inb  ? loc_wdata  : '0;
        // outbound bell: local sets, host clears
        set_mask[1] = loc_outb  ? loc_wdata  : '0;
        clr_mask[1] = host_outb ? host_wdata : '0;

        // enable register: local side only (R6)
        ena_we    = loc_we && (bell_slot_e'(loc_addr) == SLOT_ENA);
        ena_wdata = loc_wdata[ENA_BITS-1:0];
    end

endmodule

// File: rtl/bell_cell.sv
module bell_cell #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    input  logic             irq_en,
    output logic [WIDTH-1:0] bits,
    output logic             irq
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over clear on the same bit (R5)
        st_d.bits = (st_q.bits & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;
    assign irq  = irq_en && (|st_q.bits);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((st_q.bits & $past(set_mask)) == $past(set_mask)));

    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_mask)) |=> ((st_q.bits & $past(clr_mask & ~set_mask)) == '0));

    a_r4_zero_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.bits ^ $past(st_q.bits)) & ~$past(set_mask | clr_mask)) == '0));

endmodule

// File: rtl/bell_enable.sv
module bell_enable
    import bell_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ENA_BITS-1:0] wdata,
    output logic [ENA_BITS-1:0] ena
);

    typedef struct packed {
        logic [ENA_BITS-1:0] ena;
    } ena_t;

    ena_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ena = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ena = st_q.ena;

    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.ena));

endmodule

// File: rtl/bell_readmux.sv
module bell_readmux
    import bell_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]          raddr,
    input  logic [WIDTH-1:0]    inb,
    input  logic [WIDTH-1:0]    outb,
    input  logic [ENA_BITS-1:0] ena,
    output logic [WIDTH-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        unique case (bell_slot_e'(raddr))
            SLOT_INB:  rdata = inb;
            SLOT_OUTB: rdata = outb;
            SLOT_ENA:  rdata[ENA_BITS-1:0] = ena;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/bell_exchange.sv
module bell_exchange
    import bell_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [1:0]       host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic [1:0]       host_raddr,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             loc_we,
    input  logic [1:0]       loc_addr,
    input  logic [WIDTH-1:0] loc_wdata,
    input  logic [1:0]       loc_raddr,
    output logic [WIDTH-1:0] loc_rdata,
    output logic             irq_loc,
    output logic             irq_host
);

    logic [NUM_BELLS-1:0][WIDTH-1:0] set_mask;
    logic [NUM_BELLS-1:0][WIDTH-1:0] clr_mask;
    logic [NUM_BELLS-1:0][WIDTH-1:0] bell_bits;
    logic [NUM_BELLS-1:0]            bell_irq;
    logic                            ena_we;
    logic [ENA_BITS-1:0]             ena_wdata;
    logic [ENA_BITS-1:0]             ena;

    bell_decode #(.WIDTH(WIDTH)) u_decode (
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .loc_we     (loc_we),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .ena_we     (ena_we),
        .ena_wdata  (ena_wdata)
    );

    bell_enable u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ena_we),
        .wdata (ena_wdata),
        .ena   (ena)
    );

    for (genvar g = 0; g < NUM_BELLS; g++) begin : g_bell
        bell_cell #(.WIDTH(WIDTH)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask[g]),
            .clr_mask (clr_mask[g]),
            .irq_en   (ena[g]),
            .bits     (bell_bits[g]),
            .irq      (bell_irq[g])
        );
    end

    bell_readmux #(.WIDTH(WIDTH)) u_rd_host (
        .raddr (host_raddr),
        .inb   (bell_bits[0]),
        .outb  (bell_bits[1]),
        .ena   (ena),
        .rdata (host_rdata)
    );

    bell_readmux #(.WIDTH(WIDTH)) u_rd_loc (
        .raddr (loc_raddr),
        .inb   (bell_bits[0]),
        .outb  (bell_bits[1]),
        .ena   (ena),
        .rdata (loc_rdata)
    );

    assign irq_loc  = bell_irq[ENA_INB];
    assign irq_host = bell_irq[ENA_OUTB];

    a_r6_host_cannot_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == SLOT_ENA && !(loc_we && loc_addr == SLOT_ENA))
        |=> $stable(ena));

    a_r7_irq_loc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_loc |-> (ena[ENA_INB] && bell_bits[0] != '0));

    a_r7_irq_host_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_host |-> (ena[ENA_OUTB] && bell_bits[1] != '0));

    a_r8_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_raddr == SLOT_RSVD) |-> (host_rdata == '0));

    a_r8_only_writes_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !loc_we) |=> ($stable(bell_bits) && $stable(ena)));

endmodule

// File: tb/test_bell_exchange.sv
`timescale 1ns/1ps
module test_bell_exchange;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_we = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [W-1:0] host_wdata = '0;
    logic [1:0]   host_raddr = '0;
    logic [W-1:0] host_rdata;
    logic         loc_we = 1'b0;
    logic [1:0]   loc_addr = '0;
    logic [W-1:0] loc_wdata = '0;
    logic [1:0]   loc_raddr = '0;
    logic [W-1:0] loc_rdata;
    logic         irq_loc, irq_host;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_inb = '0, m_outb = '0;
    logic [1:0]   m_ena = '0;

    always #4 clk = ~clk;

    bell_exchange #(.WIDTH(W)) i_bell_exchange (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_raddr(loc_raddr), .loc_rdata(loc_rdata),
        .irq_loc(irq_loc), .irq_host(irq_host)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one write cycle; model follows the requirements
    task automatic op(input logic hwe, input logic [1:0] ha, input logic [W-1:0] hd,
                      input logic lwe, input logic [1:0] la, input logic [W-1:0] ld);
        logic [W-1:0] s_in, c_in, s_out, c_out;
        @(negedge clk);
        host_we = hwe; host_addr = ha; host_wdata = hd;
        loc_we = lwe; loc_addr = la; loc_wdata = ld;
        @(posedge clk);
        #1;
        host_we = 1'b0; loc_we = 1'b0;
        s_in  = (hwe && ha == 2'd0) ? hd : '0;   // R2
        c_in  = (lwe && la == 2'd0) ? ld : '0;
        s_out = (lwe && la == 2'd1) ? ld : '0;   // R3
        c_out = (hwe && ha == 2'd1) ? hd : '0;
        m_inb  = (m_inb  & ~c_in)  | s_in;       // R4, R5
        m_outb = (m_outb & ~c_out) | s_out;
        if (lwe && la == 2'd2) m_ena = ld[1:0];  // R6
    endtask

    task automatic check_all(input string tag);
        logic [W-1:0] exp_v;
        for (int a = 0; a < 4; a++) begin
            host_raddr = 2'(a);
            loc_raddr  = 2'(3 - a);
            #0.4;
            case (a)
                0: exp_v = m_inb;
                1: exp_v = m_outb;
                2: exp_v = W'(m_ena);
                default: exp_v = '0;             // R8
            endcase
            check({tag, " host read"}, int'(host_rdata), int'(exp_v));
            case (3 - a)
                0: exp_v = m_inb;
                1: exp_v = m_outb;
                2: exp_v = W'(m_ena);
                default: exp_v = '0;
            endcase
            check({tag, " local read"}, int'(loc_rdata), int'(exp_v));
        end
        check("R7 irq_loc", int'(irq_loc), int'(m_ena[0] && m_inb != '0));
        check("R7 irq_host", int'(irq_host), int'(m_ena[1] && m_outb != '0));
    endtask

    initial begin : watchdog
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1 after release");

        // R6: host write to enable slot ignored, local write takes
        op(1'b1, 2'd2, '1, 1'b0, 2'd0, '0);
        check_all("R6 host enable write");
        op(1'b0, 2'd0, '0, 1'b1, 2'd2, 4'b0011);
        check_all("R6 local enable write");

        // R8: slot 3 writes from both sides change nothing
        op(1'b1, 2'd3, '1, 1'b1, 2'd3, '1);
        check_all("R8 reserved write");

        // R2 / R4 / R5 exhaustive on inbound bell
        for (int s = 0; s < N; s++) begin
            op(1'b0, 2'd0, '0, 1'b1, 2'd2, W'(s & 3));
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    op(1'b1, 2'd0, W'(s), 1'b1, 2'd0, '1);
                    op(1'b1, 2'd0, W'(a), 1'b1, 2'd0, W'(b));
                    check_all("R2 R5 inbound");
                end
            end
        end

        // R3 / R4 / R5 exhaustive on outbound bell
        for (int s = 0; s < N; s++) begin
            op(1'b0, 2'd0, '0, 1'b1, 2'd2, W'((s + 1) & 3));
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    op(1'b1, 2'd1, '1, 1'b1, 2'd1, W'(s));
                    op(1'b1, 2'd1, W'(b), 1'b1, 2'd1, W'(a));
                    check_all("R3 R5 outbound");
                end
            end
        end

        // R7 level hold: idle cycles keep state and interrupts
        op(1'b1, 2'd0, 4'b0100, 1'b1, 2'd2, 4'b0011);
        op(1'b0, 2'd0, '0, 1'b1, 2'd1, 4'b1000);
        repeat (4) begin
            op(1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
            check_all("R7 R8 idle hold");
        end
        op(1'b0, 2'd0, '0, 1'b1, 2'd2, 4'b0000);
        check_all("R7 enable removed");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule